// File: doc/BRIEF.md
# Sub-block Bridge Quiesce and Reset Sequencer

This controller takes a sub-block that sits inside an already powered domain into service and out of it again. It drives four things: the sub-block's active-low reset line, its clock enable, and the stop requests of the two sides (master and slave) of an asynchronous bus bridge that joins the sub-block to the rest of the chip. Each bridge side answers its stop request with an acknowledge input. A stopped side holds its acknowledge high. A running side holds it low.

Software or a power manager issues one of three commands: enable, disable or reset. The controller then runs the matching ordered sequence. On enable it gives the clock a burst while the sub-block is still held in reset, so the reset reaches every flop. Then it releases reset, restarts the clock and restarts the bridge sides. On disable it stops the bridge sides, stops the clock and asserts reset. A reset command is a disable followed by an enable. Every handshake wait has a bounded timeout. When a wait times out, the controller undoes the steps it has already taken and ends the sequence with an error. A build option covers sub-blocks that have no bridge; in that case only clock and reset are sequenced.

Top module: `svc_seq`

## Requirements
- R1: While reset is applied and after it, subRstN is 0, subClkEn is 0, mstStopReq and slvStopReq are 1, and busy, done and err are 0.
- R2: On enable, subClkEn goes high at the accept edge and stays high for exactly CLK_PULSE_CYC cycles while subRstN stays 0. subClkEn then drops. subRstN rises one cycle later, and subClkEn rises again one cycle after that.
- R3: With a bridge, mstStopReq is cleared in the same cycle that the clock restarts. Once mstStopAck is sampled low, slvStopReq is cleared. Once slvStopAck is sampled low, the enable ends with done and no err. A stop request is never driven both ways in the same cycle.
- R4: If the master side does not restart, the enable drops subClkEn, asserts reset one cycle later and ends with err. If the slave side does not restart, mstStopReq is set again and its acknowledge is awaited first, and the same clock-then-reset failure tail follows.
- R5: On disable with a bridge, slvStopReq is set at the accept edge. After slvStopAck is sampled high, mstStopReq is set. After mstStopAck is sampled high, subClkEn drops, and one cycle later subRstN drops with done. Reset is only ever asserted while the clock is off.
- R6: If the slave side does not stop, the disable ends with err at the timeout edge, and clock, reset and the master request stay as they were. If the master side does not stop, slvStopReq is cleared and its acknowledge is awaited, then the disable ends with err; clock and reset stay untouched.
- R7: A handshake wait fails when the acknowledge has not reached its target level on ACK_TIMEOUT_CYC consecutive edges after the request changed. An acknowledge that reaches its target on the last of those edges still counts as success.
- R8: A reset command runs the disable sequence. Instead of finishing, it starts the enable sequence one cycle after reset is asserted. If the disable part fails, the command ends with err and no enable step follows.
- R9: cmdOp encodes 0 = none, 1 = enable, 2 = disable, 3 = reset. A command is accepted on a clock edge where cmdValid is 1, cmdOp is not 0 and busy is 0. A command presented while busy, or with op 0, has no effect.
- R10: done is a one-cycle pulse that ends each accepted command. err is 1 only together with done. busy is 1 from the cycle after the accept edge up to and including the cycle before done rises, and is 0 while done is high.
- R11: Built without a bridge, both stop requests stay at 1. The enable signals done CLK_PULSE_CYC+2 edges after the accept edge. The disable drops the clock at the accept edge and asserts reset with done on the next edge.
- R12: subInReset is always the inverse of subRstN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Command code (0 none, 1 enable, 2 disable, 3 reset) |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| err | output | 1 | The ending command failed (valid with done) |
| subClkEn | output | 1 | Clock enable of the sub-block |
| subRstN | output | 1 | Reset of the sub-block, active low |
| subInReset | output | 1 | Status: sub-block is currently held in reset |
| mstStopReq | output | 1 | Stop request to the master side of the bridge |
| mstStopAck | input | 1 | Master side acknowledge (high when stopped) |
| slvStopReq | output | 1 | Stop request to the slave side of the bridge |
| slvStopAck | input | 1 | Slave side acknowledge (high when stopped) |

## Verification
The bench goes after acknowledge handling at each of the six wait points by holding one bridge side stuck. A design that counted the timeout one edge off, skipped an undo step, or carried on into enable after a failed disable inside a reset would show a request or clock level that diverges from the reference within a cycle. The clock burst length and the one-cycle spacing of clock stop, reset release and clock restart are compared every cycle, so an off-by-one burst or a reset released with the clock running is caught. Commands presented while busy, and the null code, are also driven; a design that accepted them would start a second sequence visible on the clock and request outputs.

// File: rtl/svc_seq_pkg.sv
package svc_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_ENABLE  = 2'd1,
    OP_DISABLE = 2'd2,
    OP_RESET   = 2'd3
  } cmd_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PULSE,
    S_REL,
    S_CLKON,
    S_E_MST,
    S_E_SLV,
    S_E_UNDO,
    S_FAIL,
    S_D_SLV,
    S_D_MST,
    S_D_UNDO,
    S_D_RST,
    S_E_START
  } seq_state_e;

  // Strobes from the control FSM to the output register file.
  typedef struct packed {
    logic clkOn;
    logic clkOff;
    logic rstRelease;
    logic rstAssert;
    logic mstStop;
    logic mstRun;
    logic slvStop;
    logic slvRun;
    logic done;
    logic err;
  } seq_strobe_t;

endpackage

// File: rtl/svc_seq_ctrl.sv
module svc_seq_ctrl
  import svc_seq_pkg::*;
#(
  parameter int HAS_BRIDGE      = 1,
  parameter int CLK_PULSE_CYC   = 32,
  parameter int ACK_TIMEOUT_CYC = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        mstStopAck,
  input  logic        slvStopAck,
  output logic        busy,
  output seq_strobe_t strobe
);

  localparam int CNT_MAX = (CLK_PULSE_CYC > ACK_TIMEOUT_CYC) ? CLK_PULSE_CYC : ACK_TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(CLK_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(ACK_TIMEOUT_CYC - 1);
  localparam bit BRIDGED = (HAS_BRIDGE != 0);

  seq_state_e       state, stateN;
  logic [CNT_W-1:0] cnt, cntN, cntInc;
  logic             resetOp, resetOpN;
  logic             lastPulse, ackExpired;
  cmd_op_e          op;

  assign op         = cmd_op_e'(cmdOp);
  assign cntInc     = cnt + CNT_W'(1);
  assign lastPulse  = (cnt == PULSE_LAST);
  assign ackExpired = (cnt == WAIT_LAST);
  assign busy       = (state != S_IDLE);

  always_comb begin
    strobe   = '0;
    stateN   = state;
    cntN     = cnt;
    resetOpN = resetOp;
    case (state)
      S_IDLE: begin
        if (cmdValid && op != OP_NONE) begin
          resetOpN = (op == OP_RESET);
          cntN     = '0;
          if (op == OP_ENABLE) begin
            strobe.clkOn = 1'b1;
            stateN       = S_PULSE;
          end else if (BRIDGED) begin
            strobe.slvStop = 1'b1;
            stateN         = S_D_SLV;
          end else begin
            strobe.clkOff = 1'b1;
            stateN        = S_D_RST;
          end
        end
      end
      S_PULSE: begin
        if (lastPulse) begin
          strobe.clkOff = 1'b1;
          stateN        = S_REL;
        end else begin
          cntN = cntInc;
        end
      end
      S_REL: begin
        strobe.rstRelease = 1'b1;
        stateN            = S_CLKON;
      end
      S_CLKON: begin
        strobe.clkOn = 1'b1;
        cntN         = '0;
        if (BRIDGED) begin
          strobe.mstRun = 1'b1;
          stateN        = S_E_MST;
        end else begin
          strobe.done = 1'b1;
          stateN      = S_IDLE;
        end
      end
      S_E_MST: begin
        if (!mstStopAck) begin
          strobe.slvRun = 1'b1;
          cntN          = '0;
          stateN        = S_E_SLV;
        end else if (ackExpired) begin
          strobe.clkOff = 1'b1;
          stateN        = S_FAIL;
        end else begin
          cntN = cntInc;
        end
      end
      S_E_SLV: begin
        if (!slvStopAck) begin
          strobe.done = 1'b1;
          stateN      = S_IDLE;
        end else if (ackExpired) begin
          strobe.mstStop = 1'b1;
          cntN           = '0;
          stateN         = S_E_UNDO;
        end else begin
          cntN = cntInc;
        end
      end
      S_E_UNDO: begin
        if (mstStopAck || ackExpired) begin
          strobe.clkOff = 1'b1;
          stateN        = S_FAIL;
        end else begin
          cntN = cntInc;
        end
      end
      S_FAIL: begin
        strobe.rstAssert = 1'b1;
        strobe.done      = 1'b1;
        strobe.err       = 1'b1;
        stateN           = S_IDLE;
      end
      S_D_SLV: begin
        if (slvStopAck) begin
          strobe.mstStop = 1'b1;
          cntN           = '0;
          stateN         = S_D_MST;
        end else if (ackExpired) begin
          strobe.done = 1'b1;
          strobe.err  = 1'b1;
          stateN      = S_IDLE;
        end else begin
          cntN = cntInc;
        end
      end
      S_D_MST: begin
        if (mstStopAck) begin
          strobe.clkOff = 1'b1;
          stateN        = S_D_RST;
        end else if (ackExpired) begin
          strobe.slvRun = 1'b1;
          cntN          = '0;
          stateN        = S_D_UNDO;
        end else begin
          cntN = cntInc;
        end
      end
      S_D_UNDO: begin
        if (!slvStopAck || ackExpired) begin
          strobe.done = 1'b1;
          strobe.err  = 1'b1;
          stateN      = S_IDLE;
        end else begin
          cntN = cntInc;
        end
      end
      S_D_RST: begin
        strobe.rstAssert = 1'b1;
        if (resetOp) begin
          stateN = S_E_START;
        end else begin
          strobe.done = 1'b1;
          stateN      = S_IDLE;
        end
      end
      S_E_START: begin
        strobe.clkOn = 1'b1;
        cntN         = '0;
        stateN       = S_PULSE;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      resetOp <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      resetOp <= resetOpN;
    end
  end

  // R7: the wait counter never passes the timeout window
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_E_MST, S_E_SLV, S_E_UNDO, S_D_SLV, S_D_MST, S_D_UNDO})
      |-> (cnt <= WAIT_LAST));

  // R10: a finishing strobe always returns the FSM to idle
  p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> (state == S_IDLE));

endmodule

// File: rtl/svc_seq_path.sv
module svc_seq_path
  import svc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  output logic        subClkEn,
  output logic        subRstN,
  output logic        mstStopReq,
  output logic        slvStopReq,
  output logic        done,
  output logic        err
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subClkEn   <= 1'b0;
      subRstN    <= 1'b0;
      mstStopReq <= 1'b1;
      slvStopReq <= 1'b1;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (strobe.clkOn)           subClkEn <= 1'b1;
      else if (strobe.clkOff)     subClkEn <= 1'b0;
      if (strobe.rstRelease)      subRstN <= 1'b1;
      else if (strobe.rstAssert)  subRstN <= 1'b0;
      if (strobe.mstStop)         mstStopReq <= 1'b1;
      else if (strobe.mstRun)     mstStopReq <= 1'b0;
      if (strobe.slvStop)         slvStopReq <= 1'b1;
      else if (strobe.slvRun)     slvStopReq <= 1'b0;
      done <= strobe.done;
      err  <= strobe.err;
    end
  end

  // R2: reset is released only while the clock is stopped
  p_release_clk_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(subRstN) |-> !subClkEn);

  // R5: reset is asserted only while the clock is stopped
  p_assert_clk_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(subRstN) |-> !subClkEn);

  // R3: no bridge request is driven both ways at once
  p_req_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.mstStop && strobe.mstRun) && !(strobe.slvStop && strobe.slvRun));

  // R10: err only accompanies done
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/svc_seq.sv
module svc_seq
  import svc_seq_pkg::*;
#(
  parameter int HAS_BRIDGE      = 1,
  parameter int CLK_PULSE_CYC   = 32,
  parameter int ACK_TIMEOUT_CYC = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       subClkEn,
  output logic       subRstN,
  output logic       subInReset,
  output logic       mstStopReq,
  input  logic       mstStopAck,
  output logic       slvStopReq,
  input  logic       slvStopAck
);

  seq_strobe_t strobe;

  svc_seq_ctrl #(
    .HAS_BRIDGE     (HAS_BRIDGE),
    .CLK_PULSE_CYC  (CLK_PULSE_CYC),
    .ACK_TIMEOUT_CYC(ACK_TIMEOUT_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .mstStopAck(mstStopAck),
    .slvStopAck(slvStopAck),
    .busy      (busy),
    .strobe    (strobe)
  );

  svc_seq_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .subClkEn  (subClkEn),
    .subRstN   (subRstN),
    .mstStopReq(mstStopReq),
    .slvStopReq(slvStopReq),
    .done      (done),
    .err       (err)
  );

  assign subInReset = ~subRstN;

  // R10: busy has dropped by the time done is seen
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/svc_seq_tb.sv
module svc_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P   = 32;
  localparam int TO  = 10;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic nbValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic mAck = 1'b1;
  logic sAck = 1'b1;
  bit mStuck = 1'b0;
  bit sStuck = 1'b0;
  int mCnt = 0;
  int sCnt = 0;

  logic busy, done, err, clkEn, rstLine, inRst, mReq, sReq;
  logic nbBusy, nbDone, nbErr, nbClk, nbRst, nbInRst, nbMReq, nbSReq;

  svc_seq #(.HAS_BRIDGE(1), .CLK_PULSE_CYC(P), .ACK_TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .busy(busy), .done(done), .err(err), .subClkEn(clkEn), .subRstN(rstLine),
    .subInReset(inRst), .mstStopReq(mReq), .mstStopAck(mAck),
    .slvStopReq(sReq), .slvStopAck(sAck));

  svc_seq #(.HAS_BRIDGE(0), .CLK_PULSE_CYC(P), .ACK_TIMEOUT_CYC(TO)) u_nob (
    .clk(clk), .rstN(rstN), .cmdValid(nbValid), .cmdOp(cmdOp),
    .busy(nbBusy), .done(nbDone), .err(nbErr), .subClkEn(nbClk), .subRstN(nbRst),
    .subInReset(nbInRst), .mstStopReq(nbMReq), .mstStopAck(1'b0),
    .slvStopReq(nbSReq), .slvStopAck(1'b0));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit compareOn = 1'b0;

  bit eClk = 0, eRst = 0, eMst = 1, eSlv = 1, eBusy = 0, eDone = 0, eErr = 0;

  task automatic checkEq(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Bridge model: acknowledge follows request after LAT negedges unless stuck.
  always @(negedge clk) begin
    if (!mStuck) begin
      if (mAck != mReq) begin
        mCnt++;
        if (mCnt >= LAT) begin mAck = mReq; mCnt = 0; end
      end else mCnt = 0;
    end
    if (!sStuck) begin
      if (sAck != sReq) begin
        sCnt++;
        if (sCnt >= LAT) begin sAck = sReq; sCnt = 0; end
      end else sCnt = 0;
    end
  end

  // Per-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (compareOn) begin
      checkEq("R2",  "subClkEn",   int'(clkEn),   int'(eClk));
      checkEq("R2",  "subRstN",    int'(rstLine), int'(eRst));
      checkEq("R12", "subInReset", int'(inRst),   int'(!eRst));
      checkEq("R3",  "mstStopReq", int'(mReq),    int'(eMst));
      checkEq("R5",  "slvStopReq", int'(sReq),    int'(eSlv));
      checkEq("R10", "busy",       int'(busy),    int'(eBusy));
      checkEq("R10", "done",       int'(done),    int'(eDone));
      checkEq("R10", "err",        int'(err),     int'(eErr));
    end
  end

  // Reference model: behavioural, one step per rising edge.
  task automatic step();
    @(posedge clk);
  endtask

  task automatic waitAck(bit useM, bit target, output bit ok);
    ok = 1'b0;
    for (int j = 1; j <= TO; j++) begin
      step();
      if ((useM ? mAck : sAck) == target) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic finishFail();
    eClk = 0;
    step();
    eRst = 0; eDone = 1; eErr = 1; eBusy = 0;
  endtask

  task automatic modelEnable();
    bit ok;
    eClk = 1;
    repeat (P) step();
    eClk = 0;
    step();
    eRst = 1;
    step();
    eClk = 1; eMst = 0;
    waitAck(1'b1, 1'b0, ok);
    if (!ok) begin finishFail(); return; end
    eSlv = 0;
    waitAck(1'b0, 1'b0, ok);
    if (ok) begin eDone = 1; eBusy = 0; return; end
    eMst = 1;
    waitAck(1'b1, 1'b1, ok);
    finishFail();
  endtask

  task automatic modelDisable(bit isReset);
    bit ok;
    eSlv = 1;
    waitAck(1'b0, 1'b1, ok);
    if (!ok) begin eDone = 1; eErr = 1; eBusy = 0; return; end
    eMst = 1;
    waitAck(1'b1, 1'b1, ok);
    if (!ok) begin
      eSlv = 0;
      waitAck(1'b0, 1'b0, ok);
      eDone = 1; eErr = 1; eBusy = 0;
      return;
    end
    eClk = 0;
    step();
    eRst = 0;
    if (isReset) begin
      step();
      modelEnable();
    end else begin
      eDone = 1; eBusy = 0;
    end
  endtask

  initial begin : refModel
    @(posedge rstN);
    forever begin
      step();
      eDone = 0; eErr = 0;
      if (cmdValid && cmdOp != 2'd0) begin
        eBusy = 1;
        if (cmdOp == 2'd1) modelEnable();
        else modelDisable(cmdOp == 2'd3);
      end
    end
  end

  // Stimulus helpers
  task automatic pulseCmd(bit nb, logic [1:0] op);
    @(negedge clk);
    cmdOp = op;
    if (nb) nbValid = 1'b1; else cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    nbValid = 1'b0;
  endtask

  task automatic waitDone(bit nb, output int cyc, output bit e);
    cyc = 1;
    e = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cyc++;
      if (nb ? nbDone : done) begin
        e = nb ? nbErr : err;
        return;
      end
    end
    checkEq("R10", "done never seen", 0, 1);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin : main
    int c;
    bit e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checkEq("R1", "subRstN", int'(rstLine), 0);
    checkEq("R1", "subClkEn", int'(clkEn), 0);
    checkEq("R1", "mstStopReq", int'(mReq), 1);
    checkEq("R1", "slvStopReq", int'(sReq), 1);
    checkEq("R1", "busy", int'(busy), 0);
    checkEq("R1", "done", int'(done), 0);
    checkEq("R1", "err", int'(err), 0);
    rstN = 1'b1;
    compareOn = 1'b1;

    // R3: plain enable, with a disable attempted while busy (R9)
    pulseCmd(1'b0, 2'd1);
    settle(4);
    pulseCmd(1'b0, 2'd2);
    waitDone(1'b0, c, e);
    checkEq("R3", "enable err", int'(e), 0);
    checkEq("R3", "mstStopReq after enable", int'(mReq), 0);
    checkEq("R3", "slvStopReq after enable", int'(sReq), 0);
    settle(3);
    checkEq("R9", "clock kept after ignored disable", int'(clkEn), 1);
    checkEq("R9", "busy after ignored disable", int'(busy), 0);

    // R9: null op has no effect
    pulseCmd(1'b0, 2'd0);
    settle(5);
    checkEq("R9", "busy after null op", int'(busy), 0);
    checkEq("R9", "reset line after null op", int'(rstLine), 1);

    // R5: plain disable
    pulseCmd(1'b0, 2'd2);
    waitDone(1'b0, c, e);
    checkEq("R5", "disable err", int'(e), 0);
    checkEq("R5", "clock off", int'(clkEn), 0);
    checkEq("R5", "reset asserted", int'(rstLine), 0);
    checkEq("R12", "status in reset", int'(inRst), 1);

    // R8: reset command from enabled state
    pulseCmd(1'b0, 2'd1);
    waitDone(1'b0, c, e);
    pulseCmd(1'b0, 2'd3);
    waitDone(1'b0, c, e);
    checkEq("R8", "reset cmd err", int'(e), 0);
    checkEq("R8", "clock on after reset cmd", int'(clkEn), 1);
    checkEq("R8", "reset released after reset cmd", int'(rstLine), 1);

    // R4 / R7: master never restarts
    pulseCmd(1'b0, 2'd2);
    waitDone(1'b0, c, e);
    settle(3);
    mStuck = 1'b1;
    pulseCmd(1'b0, 2'd1);
    waitDone(1'b0, c, e);
    checkEq("R4", "master fail err", int'(e), 1);
    checkEq("R7", "master fail latency", c, P + TO + 4);
    checkEq("R4", "clock off after master fail", int'(clkEn), 0);
    checkEq("R4", "reset after master fail", int'(rstLine), 0);
    mStuck = 1'b0;
    settle(5);

    // R4: slave never restarts, master is stopped again
    sStuck = 1'b1;
    pulseCmd(1'b0, 2'd1);
    waitDone(1'b0, c, e);
    checkEq("R4", "slave fail err", int'(e), 1);
    checkEq("R4", "master re-stopped", int'(mReq), 1);
    checkEq("R4", "reset after slave fail", int'(rstLine), 0);
    sStuck = 1'b0;
    settle(5);

    // R6: slave never stops during disable
    pulseCmd(1'b0, 2'd1);
    waitDone(1'b0, c, e);
    settle(2);
    sStuck = 1'b1;
    pulseCmd(1'b0, 2'd2);
    waitDone(1'b0, c, e);
    checkEq("R6", "slave stop fail err", int'(e), 1);
    checkEq("R7", "slave stop fail latency", c, TO + 1);
    checkEq("R6", "clock untouched", int'(clkEn), 1);
    checkEq("R6", "master request untouched", int'(mReq), 0);
    sStuck = 1'b0;
    settle(5);

    // R6: master never stops, slave restarted
    mStuck = 1'b1;
    pulseCmd(1'b0, 2'd2);
    waitDone(1'b0, c, e);
    checkEq("R6", "master stop fail err", int'(e), 1);
    checkEq("R6", "slave restarted", int'(sReq), 0);
    checkEq("R6", "reset untouched", int'(rstLine), 1);
    mStuck = 1'b0;
    settle(5);

    // R8: reset command aborts when disable part fails
    sStuck = 1'b1;
    pulseCmd(1'b0, 2'd3);
    waitDone(1'b0, c, e);
    checkEq("R8", "reset abort err", int'(e), 1);
    checkEq("R8", "reset abort latency", c, TO + 1);
    settle(3);
    checkEq("R8", "no enable after abort clk", int'(clkEn), 1);
    checkEq("R8", "no enable after abort busy", int'(busy), 0);
    sStuck = 1'b0;
    settle(5);

    // R11: variant without bridge
    pulseCmd(1'b1, 2'd1);
    waitDone(1'b1, c, e);
    checkEq("R11", "no-bridge enable latency", c, P + 3);
    checkEq("R11", "no-bridge enable err", int'(e), 0);
    checkEq("R11", "no-bridge clock", int'(nbClk), 1);
    checkEq("R11", "no-bridge reset", int'(nbRst), 1);
    checkEq("R11", "no-bridge mst req", int'(nbMReq), 1);
    checkEq("R11", "no-bridge slv req", int'(nbSReq), 1);
    pulseCmd(1'b1, 2'd2);
    waitDone(1'b1, c, e);
    checkEq("R11", "no-bridge disable latency", c, 2);
    checkEq("R11", "no-bridge clock off", int'(nbClk), 0);
    checkEq("R11", "no-bridge reset asserted", int'(nbRst), 0);
    checkEq("R12", "no-bridge status", int'(nbInRst), 1);

    settle(3);
    finishRun();
  end

endmodule